// File: doc/BRIEF.md
# Buffered compare PWM generator

This block drives one PWM output. A prescaler and a power-of-two divider turn the input clock into a slower tick. The tick decrements a period counter. Each PWM cycle has two parts: a low phase, and then a high phase. The high phase lasts one tick longer than the compare value. The full cycle lasts one tick longer than the period value.

New period and compare values go into holding registers, which have their own write strobes. The active registers take these held values at only two moments:

- when the counter wraps at the end of a cycle, or
- while the block is disabled.

As a result, a cycle that is already running is never changed by a write. The prescale and divider selections are live inputs and are not held back.

When the enable is low, the output is forced low and the counter waits at the held period value. When the enable rises, a fresh cycle starts, beginning with its low phase.

Top module: `pwm_shadow_gen`

## Requirements
- R1: After reset all counters and both register pairs are zero and the output is low while disabled; enabling with no prior writes (period 0, compare 0) gives a constantly high output.
- R2: While `en` is low, `pwm_out` is low and the counter holds the held period value.
- R3: When `en` rises, the active registers already hold the latest held values and a fresh cycle begins with its low phase, lasting (period − compare) ticks.
- R4: With compare < period, each cycle is (period − compare) ticks low followed by (compare + 1) ticks high.
- R5: With compare ≥ period, the output stays high for the whole cycle.
- R6: With compare = 0, the output is high for exactly 1 tick and low for period ticks.
- R7: One tick lasts (prescale + 1) × divide clock cycles; prescale 0 means divide-by-1.
- R8: `div_sel` codes 0, 1, 2 and 3 select divide-by 1, 2, 4 and 8; codes 4 to 7 select divide-by 16.
- R9: A compare write during a running cycle leaves that cycle unchanged and takes effect from the next cycle.
- R10: A period write during a running cycle leaves that cycle unchanged and takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low forces output low and holds counter |
| prescale | input | 8 | Prescaler value, tick divide is prescale+1 |
| div_sel | input | 3 | Divider code (1, 2, 4, 8, 16) |
| per_wr | input | 1 | Write strobe for the held period |
| per_in | input | 16 | Period value to hold |
| cmp_wr | input | 1 | Write strobe for the held compare |
| cmp_in | input | 16 | Compare value to hold |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures phase lengths in clock cycles at a rising output edge, at several compare/period pairs and tick rates.

- **Compare 0 and compare ≥ period.** An off-by-one in the compare test would show here as a missing high tick, or as a short low glitch.
- **Writes during the high phase.** A design that loads the active registers straight away would shorten or stretch the cycle already in progress.
- **Divider codes 3 and 7.** A wrong mask would give the wrong tick length.
- **Disable and re-enable.** A design that resumed mid-count, or that missed writes made while disabled, would give a low phase of the wrong length.

// File: rtl/pwm_shadow_gen.sv
module pwm_shadow_gen #(
  parameter int CW  = 16,
  parameter int PSW = 8,
  parameter int DSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [PSW-1:0] prescale,
  input  logic [DSW-1:0] div_sel,
  input  logic           per_wr,
  input  logic [CW-1:0]  per_in,
  input  logic           cmp_wr,
  input  logic [CW-1:0]  cmp_in,
  output logic           pwm_out
);
  localparam int DCW = 4;

  logic [PSW-1:0] pre_cnt;
  logic [DCW-1:0] div_cnt, div_mask;
  logic [CW-1:0]  sh_per, sh_cmp, act_per, act_cmp, cnt;
  logic           pre_hit, tick, wrap;

  always_comb begin
    case (div_sel)
      3'd0:    div_mask = 4'h0;
      3'd1:    div_mask = 4'h1;
      3'd2:    div_mask = 4'h3;
      3'd3:    div_mask = 4'h7;
      default: div_mask = 4'hF;
    endcase
  end

  assign pre_hit = pre_cnt == prescale;
  assign tick    = pre_hit && ((div_cnt & div_mask) == div_mask);
  assign wrap    = tick && cnt == '0;
  assign pwm_out = en && cnt <= act_cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!en) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_hit) begin
      pre_cnt <= '0;
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per <= '0;
      sh_cmp <= '0;
    end else begin
      if (per_wr) sh_per <= per_in;
      if (cmp_wr) sh_cmp <= cmp_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per <= '0;
      act_cmp <= '0;
      cnt     <= '0;
    end else if (!en || wrap) begin
      act_per <= sh_per;
      act_cmp <= sh_cmp;
      cnt     <= sh_per;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

module pwm_shadow_gen_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pwm_out,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] act_per,
  input logic [CW-1:0] act_cmp
);
  logic at_end;
  assign at_end = tick && cnt == '0;

  assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !pwm_out);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_per);

  assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && cnt != '0) |=> cnt == $past(cnt) - CW'(1));

  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(cnt));

  assert_cmp_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !at_end) |=> $stable(act_cmp));

  assert_per_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !at_end) |=> $stable(act_per));

  assert_full_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && act_cmp >= act_per) |-> pwm_out);
endmodule

bind pwm_shadow_gen pwm_shadow_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pwm_out(pwm_out), .tick(tick),
  .cnt(cnt), .act_per(act_per), .act_cmp(act_cmp)
);

// File: tb/test_pwm_shadow_gen.sv
module test_pwm_shadow_gen;
  logic        clk = 0, rst_n = 0, en = 0;
  logic [7:0]  prescale = 0;
  logic [2:0]  div_sel = 0;
  logic        per_wr = 0, cmp_wr = 0;
  logic [15:0] per_in = 0, cmp_in = 0;
  logic        pwm_out;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  pwm_shadow_gen i_pwm_shadow_gen (.*);

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_both(input int p, input int c);
    @(negedge clk); per_wr = 1; cmp_wr = 1; per_in = 16'(p); cmp_in = 16'(c);
    @(negedge clk); per_wr = 0; cmp_wr = 0;
  endtask

  task automatic setup(input int pre, input int dsel, input int p, input int c);
    @(negedge clk); en = 0; prescale = 8'(pre); div_sel = 3'(dsel);
    write_both(p, c);
    @(negedge clk); en = 1;
  endtask

  task automatic wait_rise();
    logic prev = pwm_out;
    for (int g = 0; g < 5000; g++) begin
      @(negedge clk);
      if (!prev && pwm_out) return;
      prev = pwm_out;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise();
    hi = 0; lo = 0;
    while (pwm_out && hi < 5000) begin hi++; @(negedge clk); end
    while (!pwm_out && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  task automatic count_low(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!pwm_out) lows++; end
  endtask

  task automatic t_reset();
    int lows;
    @(negedge clk);
    chk(pwm_out, 0, "R1 output low after reset");
    @(negedge clk); en = 1;
    count_low(20, lows);
    chk(lows, 0, "R1 zero registers give constant high");
  endtask

  task automatic t_basic();
    int hi, lo;
    setup(0, 0, 9, 3);
    measure(hi, lo);
    chk(hi, 4, "R4 high ticks");
    chk(lo, 6, "R4 low ticks");
  endtask

  task automatic t_cmp_zero();
    int hi, lo;
    setup(0, 0, 5, 0);
    measure(hi, lo);
    chk(hi, 1, "R6 high one tick");
    chk(lo, 5, "R6 low period ticks");
  endtask

  task automatic t_full_high();
    int lows;
    setup(0, 0, 4, 7);
    count_low(30, lows);
    chk(lows, 0, "R5 compare above period");
    setup(0, 0, 4, 4);
    count_low(30, lows);
    chk(lows, 0, "R5 compare equal period");
  endtask

  task automatic t_prescale();
    int hi, lo;
    setup(2, 2, 3, 1);
    measure(hi, lo);
    chk(hi, 24, "R7 prescale x divide high");
    chk(lo, 24, "R7 prescale x divide low");
  endtask

  task automatic t_div();
    int hi, lo;
    setup(0, 3, 2, 0);
    measure(hi, lo);
    chk(hi, 8, "R8 code 3 high");
    chk(lo, 16, "R8 code 3 low");
    setup(0, 7, 1, 0);
    measure(hi, lo);
    chk(hi, 16, "R8 code 7 high");
    chk(lo, 16, "R8 code 7 low");
  endtask

  task automatic t_cmp_mid();
    int hi, lo, hi2, lo2;
    setup(0, 0, 9, 2);
    wait_rise();
    cmp_wr = 1; cmp_in = 16'd6; hi = 1;
    @(negedge clk); cmp_wr = 0;
    while (pwm_out && hi < 5000) begin hi++; @(negedge clk); end
    chk(hi, 3, "R9 current cycle keeps old compare");
    lo = 0;
    while (!pwm_out && lo < 5000) begin lo++; @(negedge clk); end
    chk(lo, 3, "R9 next cycle low uses new compare");
    measure(hi2, lo2);
    chk(hi2, 7, "R9 next cycle high uses new compare");
  endtask

  task automatic t_per_mid();
    int hi, lo;
    setup(0, 0, 5, 1);
    wait_rise();
    per_wr = 1; per_in = 16'd8; hi = 1;
    @(negedge clk); per_wr = 0;
    while (pwm_out && hi < 5000) begin hi++; @(negedge clk); end
    chk(hi, 2, "R10 current cycle keeps old period");
    lo = 0;
    while (!pwm_out && lo < 5000) begin lo++; @(negedge clk); end
    chk(lo, 7, "R10 next cycle uses new period");
  endtask

  task automatic t_disable();
    int hi, lo, lows;
    setup(0, 0, 6, 2);
    wait_rise();
    en = 0; #1;
    chk(pwm_out, 0, "R2 output low on disable");
    count_low(5, lows);
    chk(lows, 5, "R2 output stays low while disabled");
    write_both(7, 1);
    @(negedge clk); en = 1; #1;
    lo = 0;
    while (!pwm_out && lo < 5000) begin lo++; @(negedge clk); #1; end
    chk(lo, 6, "R3 fresh cycle low phase from held values");
    hi = 0;
    while (pwm_out && hi < 5000) begin hi++; @(negedge clk); #1; end
    chk(hi, 2, "R3 fresh cycle high phase");
  endtask

  bit done = 0;
  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_cmp_zero();
    t_full_high();
    t_prescale();
    t_div();
    t_cmp_mid();
    t_per_mid();
    t_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule